// File: doc/BRIEF.md
# Reset Strap Capture Sequencer

This block handles the configuration straps of a chip at power-up. Some pins have two jobs: during cold reset they are read as configuration straps, and later they are driven as ordinary outputs. While cold reset is active, the block turns off the output drivers on these pins and turns on their weak pull paths. It passes the pin levels through a two-stage synchronizer. On the first clock edge after cold reset is released, it stores the synchronized levels in a strap register.

After that edge the pins stay undriven for a fixed number of host clocks. Then the block takes over driving them. It also sequences the processor reset. The processor strap drivers switch on while the processor reset is still held. The reset is released a fixed number of clocks later, and the strap drivers are released a further fixed number of clocks after that.

A later peripheral reset only runs the processor reset sequence again. A suspend indication does nothing. Neither one reloads the captured straps or stops the block driving the pins.

Top module: `strap_capture_seq`

## Requirements
- R1: At every clock edge where `cold_rst` is sampled high, the outputs become: `strap_oe_o`=0, `strap_pull_en_o`=1, `cpu_rst_o`=1, `cpu_strap_en_o`=0, `strap_valid_o`=0 and `strap_val_o`=0.
- R2: Call E0 the first edge at which `cold_rst` is sampled low. At E0, `strap_val_o` loads the level that `strap_pin_i` held at the two edges before E0, and `strap_valid_o` rises.
- R3: `strap_oe_o` stays 0 for FLOAT_CLKS edges after E0 (default 4) and rises at edge E0+FLOAT_CLKS.
- R4: `strap_pull_en_o` falls at E0 and stays low until the next cold reset.
- R5: `cpu_strap_en_o` rises at the same edge as `strap_oe_o`. `cpu_rst_o` falls PRE_CLKS edges later (default 6).
- R6: `cpu_strap_en_o` falls POST_CLKS edges after `cpu_rst_o` falls (default 4).
- R7: Outside cold reset, `strap_val_o` and `strap_valid_o` never change, even when `periph_rst` pulses or `strap_pin_i` changes. Once `strap_oe_o` is 1, it stays 1 until the next cold reset.
- R8: Once the strap drivers are on, an edge with `periph_rst` high sets `cpu_rst_o`=1 and `cpu_strap_en_o`=1. Call X the first edge at which `periph_rst` is sampled low again. `cpu_rst_o` falls at X+PRE_CLKS and `cpu_strap_en_o` falls at X+PRE_CLKS+POST_CLKS.
- R9: `suspend` has no effect on any output.
- R10: A second cold reset restores the R1 state, and its release captures the new strap levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| cold_rst | input | 1 | Cold reset, active high, sampled synchronously |
| periph_rst | input | 1 | Peripheral reset, active high |
| suspend | input | 1 | Suspend indication |
| strap_pin_i | input | STRAP_W | Levels read back from the shared strap pins |
| strap_oe_o | output | 1 | Output enable for the shared strap pins |
| strap_pull_en_o | output | 1 | Enable for the internal strap pull paths |
| strap_val_o | output | STRAP_W | Captured strap register |
| strap_valid_o | output | 1 | The captured strap register holds valid data |
| cpu_rst_o | output | 1 | Processor reset, active high |
| cpu_strap_en_o | output | 1 | Drives the processor bus straps active |

## Verification
Every result here is a whole number of edges away from a single input event. The capture and the pull-enable change land at E0. The pins are driven from E0+4. The processor reset is released at E0+10 and the processor straps at E0+14. After a peripheral reset is released at edge X, the reset and strap releases land at X+6 and X+10. The bench model stamps each event with its edge number and derives every expected level from those stamps. Inputs are driven on falling edges, and every output is compared against the model on every falling edge, half a period after the rising edge that updated it.

// File: rtl/strap_seq_pkg.sv
package strap_seq_pkg;

    typedef enum logic [2:0] {
        ST_COLD,
        ST_FLOAT,
        ST_PRE,
        ST_HOLD,
        ST_POST,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic strap_oe;
        logic pull_en;
        logic cpu_rst;
        logic cpu_strap_en;
    } pin_ctl_t;

    localparam pin_ctl_t CTL_COLD = '{strap_oe: 1'b0, pull_en: 1'b1,
                                      cpu_rst: 1'b1, cpu_strap_en: 1'b0};

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/strap_capture_reg.sv
module strap_capture_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             cold_rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [WIDTH-1:0] val;
        logic             valid;
    } cap_t;

    cap_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (load_i) begin
            r_d.val   = d_i;
            r_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign q_o     = r_q.val;
    assign valid_o = r_q.valid;

    // R7: once valid, held until the next cold reset
    a_r7_hold_value: assert property (@(posedge clk) disable iff (cold_rst)
        (valid_o && !load_i) |=> ($stable(q_o) && valid_o));

    // R2: a load always leaves the register valid
    a_r2_load_valid: assert property (@(posedge clk) disable iff (cold_rst)
        load_i |=> valid_o);

endmodule

// File: rtl/strap_seq_fsm.sv
module strap_seq_fsm
    import strap_seq_pkg::*;
#(
    parameter int FLOAT_CLKS = 4,
    parameter int PRE_CLKS   = 6,
    parameter int POST_CLKS  = 4
) (
    input  logic     clk,
    input  logic     cold_rst,
    input  logic     periph_rst,
    output logic     cap_load_o,
    output pin_ctl_t ctl_o
);
    localparam int MAXC = (FLOAT_CLKS > PRE_CLKS)
                        ? ((FLOAT_CLKS > POST_CLKS) ? FLOAT_CLKS : POST_CLKS)
                        : ((PRE_CLKS > POST_CLKS) ? PRE_CLKS : POST_CLKS);
    localparam int CW = $clog2(MAXC + 1);

    typedef logic [CW-1:0] cnt_t;

    localparam cnt_t FLOAT_LD = cnt_t'(FLOAT_CLKS - 1);
    localparam cnt_t PRE_LD   = cnt_t'(PRE_CLKS - 1);
    localparam cnt_t POST_LD  = cnt_t'(POST_CLKS - 1);

    typedef struct packed {
        seq_state_e st;
        cnt_t       cnt;
        pin_ctl_t   ctl;
    } fsm_t;

    fsm_t r_q, r_d;

    always_comb begin
        r_d        = r_q;
        cap_load_o = 1'b0;
        case (r_q.st)
            ST_COLD: begin
                cap_load_o      = 1'b1;
                r_d.st          = ST_FLOAT;
                r_d.cnt         = FLOAT_LD;
                r_d.ctl.pull_en = 1'b0;
            end
            ST_FLOAT: begin
                if (r_q.cnt == '0) begin
                    r_d.st               = ST_PRE;
                    r_d.cnt              = PRE_LD;
                    r_d.ctl.strap_oe     = 1'b1;
                    r_d.ctl.cpu_strap_en = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (r_q.cnt == '0) begin
                    r_d.st          = ST_POST;
                    r_d.cnt         = POST_LD;
                    r_d.ctl.cpu_rst = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_POST: begin
                if (r_q.cnt == '0) begin
                    r_d.st               = ST_RUN;
                    r_d.ctl.cpu_strap_en = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            ST_HOLD: begin
                if (!periph_rst) begin
                    r_d.st  = ST_PRE;
                    r_d.cnt = PRE_LD;
                end
            end
            default: begin
            end
        endcase

        if (periph_rst && (r_q.st == ST_PRE || r_q.st == ST_POST ||
                           r_q.st == ST_RUN)) begin
            r_d.st               = ST_HOLD;
            r_d.cnt              = '0;
            r_d.ctl.cpu_rst      = 1'b1;
            r_d.ctl.cpu_strap_en = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (cold_rst) begin
            r_q.st  <= ST_COLD;
            r_q.cnt <= '0;
            r_q.ctl <= CTL_COLD;
        end else begin
            r_q <= r_d;
        end
    end

    assign ctl_o = r_q.ctl;

    // R5: processor straps already active on the edge before reset release
    a_r5_strap_lead: assert property (@(posedge clk) disable iff (cold_rst)
        $fell(ctl_o.cpu_rst) |-> (ctl_o.cpu_strap_en && $past(ctl_o.cpu_strap_en)));

    // R6: strap release only after the processor reset is gone
    a_r6_release_after: assert property (@(posedge clk) disable iff (cold_rst)
        $fell(ctl_o.cpu_strap_en) |-> (!ctl_o.cpu_rst && !$past(ctl_o.cpu_rst)));

    // R4: pull paths and pin drivers never on together
    a_r4_pull_vs_drive: assert property (@(posedge clk) disable iff (cold_rst)
        ctl_o.pull_en |-> !ctl_o.strap_oe);

    // R7: pin drivers stay on once enabled
    a_r7_oe_sticky: assert property (@(posedge clk) disable iff (cold_rst)
        ctl_o.strap_oe |=> ctl_o.strap_oe);

    // R3: pins driven only once the pull paths are gone
    a_r3_no_early_drive: assert property (@(posedge clk) disable iff (cold_rst)
        $rose(ctl_o.strap_oe) |-> !$past(ctl_o.pull_en));

endmodule

// File: rtl/strap_capture_seq.sv
module strap_capture_seq
    import strap_seq_pkg::*;
#(
    parameter int STRAP_W    = 8,
    parameter int SYNC_STG   = 2,
    parameter int FLOAT_CLKS = 4,
    parameter int PRE_CLKS   = 6,
    parameter int POST_CLKS  = 4
) (
    input  logic               clk,
    input  logic               cold_rst,
    input  logic               periph_rst,
    input  logic               suspend,
    input  logic [STRAP_W-1:0] strap_pin_i,
    output logic               strap_oe_o,
    output logic               strap_pull_en_o,
    output logic [STRAP_W-1:0] strap_val_o,
    output logic               strap_valid_o,
    output logic               cpu_rst_o,
    output logic               cpu_strap_en_o
);
    logic [STRAP_W-1:0] pin_sync;
    logic               cap_load;
    pin_ctl_t           ctl;

    strap_sync #(.WIDTH(STRAP_W), .STAGES(SYNC_STG)) u_sync (
        .clk    (clk),
        .pin_i  (strap_pin_i),
        .sync_o (pin_sync)
    );

    strap_seq_fsm #(
        .FLOAT_CLKS (FLOAT_CLKS),
        .PRE_CLKS   (PRE_CLKS),
        .POST_CLKS  (POST_CLKS)
    ) u_fsm (
        .clk        (clk),
        .cold_rst   (cold_rst),
        .periph_rst (periph_rst),
        .cap_load_o (cap_load),
        .ctl_o      (ctl)
    );

    strap_capture_reg #(.WIDTH(STRAP_W)) u_cap (
        .clk      (clk),
        .cold_rst (cold_rst),
        .load_i   (cap_load && !cold_rst),
        .d_i      (pin_sync),
        .q_o      (strap_val_o),
        .valid_o  (strap_valid_o)
    );

    assign strap_oe_o      = ctl.strap_oe;
    assign strap_pull_en_o = ctl.pull_en;
    assign cpu_rst_o       = ctl.cpu_rst;
    assign cpu_strap_en_o  = ctl.cpu_strap_en;

    // R9: lines stay driven while suspended once the processor runs
    a_r9_drive_in_suspend: assert property (@(posedge clk) disable iff (cold_rst)
        (suspend && !cpu_rst_o) |-> strap_oe_o);

    // R1: cold reset forces the safe pin state on the next edge
    a_r1_cold_state: assert property (@(posedge clk)
        cold_rst |=> (strap_pull_en_o && !strap_oe_o && cpu_rst_o && !strap_valid_o));

endmodule

// File: tb/strap_capture_seq_tb_top.sv
module strap_capture_seq_tb_top;
    localparam int W = 8;
    localparam int F = 4;
    localparam int PRE = 6;
    localparam int POST = 4;

    logic         clk = 1'b0;
    logic         cold_rst = 1'b1;
    logic         periph_rst = 1'b0;
    logic         suspend = 1'b0;
    logic [W-1:0] pins = 8'hA5;
    logic         oe, pull, valid, crst, cse;
    logic [W-1:0] val;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    strap_capture_seq dut_i (
        .clk             (clk),
        .cold_rst        (cold_rst),
        .periph_rst      (periph_rst),
        .suspend         (suspend),
        .strap_pin_i     (pins),
        .strap_oe_o      (oe),
        .strap_pull_en_o (pull),
        .strap_val_o     (val),
        .strap_valid_o   (valid),
        .cpu_rst_o       (crst),
        .cpu_strap_en_o  (cse)
    );

    // behavioural reference: timestamps per event
    int           cyc = 0;
    bit           m_cold = 1'b1;
    bit           m_hold = 1'b0;
    int           t_drv = 0;
    int           t_rel = 0;
    logic [W-1:0] h1 = '0, h2 = '0;
    logic [W-1:0] e_val = '0;
    bit           e_valid = 1'b0;
    bit           e_oe, e_pull, e_crst, e_cse;
    bit           started = 1'b0;

    always @(posedge clk) begin
        cyc++;
        started = 1'b1;
        if (cold_rst) begin
            m_cold  = 1'b1;
            m_hold  = 1'b0;
            e_val   = '0;
            e_valid = 1'b0;
        end else if (m_cold) begin
            m_cold  = 1'b0;
            e_val   = h2;
            e_valid = 1'b1;
            t_drv   = cyc + F;
            t_rel   = cyc + F + PRE;
        end else if (periph_rst && cyc > t_drv) begin
            m_hold = 1'b1;
        end else if (m_hold && !periph_rst) begin
            m_hold = 1'b0;
            t_rel  = cyc + PRE;
        end
        h2 = h1;
        h1 = pins;
        if (m_cold) begin
            e_oe = 0; e_pull = 1; e_crst = 1; e_cse = 0;
        end else begin
            e_pull = 0;
            e_oe   = (cyc >= t_drv);
            if (m_hold) begin
                e_crst = 1; e_cse = 1;
            end else begin
                e_crst = (cyc < t_rel);
                e_cse  = (cyc >= t_drv) && (cyc < t_rel + POST);
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model, half a period after the update
    always @(negedge clk) begin
        if (started) begin
            chk(m_cold ? "R1" : "R3", "strap_oe", 32'(oe), 32'(e_oe));
            chk(m_cold ? "R1" : "R4", "pull_en", 32'(pull), 32'(e_pull));
            chk(m_hold ? "R8" : "R5", "cpu_rst", 32'(crst), 32'(e_crst));
            chk(m_hold ? "R8" : "R6", "cpu_strap_en", 32'(cse), 32'(e_cse));
            chk(m_cold ? "R1" : "R7", "strap_val", 32'(val), 32'(e_val));
            chk(m_cold ? "R1" : "R2", "strap_valid", 32'(valid), 32'(e_valid));
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    logic [W-1:0] snap;

    initial begin
        wait_cyc(8);
        chk("R1", "reset outputs", {28'(0), oe, pull, crst, cse}, 32'h6);
        // release cold reset, change pins at once: capture keeps old level
        cold_rst = 1'b0;
        pins     = 8'h3C;
        wait_cyc(1);
        chk("R2", "captured", 32'(val), 32'hA5);
        chk("R4", "pull off at exit", 32'(pull), 32'h0);
        wait_cyc(3);
        chk("R3", "still floating", 32'(oe), 32'h0);
        wait_cyc(1);
        chk("R3", "driven after window", 32'(oe), 32'h1);
        chk("R5", "cpu straps on", 32'(cse), 32'h1);
        wait_cyc(5);
        chk("R5", "cpu reset held", 32'(crst), 32'h1);
        wait_cyc(1);
        chk("R5", "cpu reset released", 32'(crst), 32'h0);
        wait_cyc(3);
        chk("R6", "cpu straps held", 32'(cse), 32'h1);
        wait_cyc(1);
        chk("R6", "cpu straps released", 32'(cse), 32'h0);
        wait_cyc(5);
        // suspend with pins toggling
        snap    = val;
        suspend = 1'b1;
        for (int i = 0; i < 10; i++) begin
            pins = pins ^ 8'hFF;
            wait_cyc(1);
            chk("R9", "suspend outputs", {28'(0), oe, pull, crst, cse}, 32'h8);
        end
        suspend = 1'b0;
        chk("R9", "value in suspend", 32'(val), 32'(snap));
        // peripheral reset pulse
        periph_rst = 1'b1;
        wait_cyc(1);
        chk("R8", "cpu reset reasserted", {30'(0), crst, cse}, 32'h3);
        wait_cyc(4);
        periph_rst = 1'b0;
        wait_cyc(1);
        chk("R7", "oe during periph", 32'(oe), 32'h1);
        wait_cyc(5);
        chk("R8", "held before release", 32'(crst), 32'h1);
        wait_cyc(1);
        chk("R8", "released after pulse", 32'(crst), 32'h0);
        wait_cyc(4);
        chk("R8", "straps released", 32'(cse), 32'h0);
        chk("R7", "value after periph", 32'(val), 32'hA5);
        wait_cyc(3);
        // second cold reset with new straps
        pins     = 8'h5A;
        cold_rst = 1'b1;
        wait_cyc(1);
        chk("R10", "cold again", {28'(0), oe, pull, crst, cse}, 32'h6);
        chk("R10", "value cleared", 32'(valid), 32'h0);
        wait_cyc(6);
        cold_rst = 1'b0;
        pins     = 8'h00;
        wait_cyc(1);
        chk("R10", "new capture", 32'(val), 32'h5A);
        // periph during the pre-release window and during the post window
        wait_cyc(6);
        periph_rst = 1'b1;
        wait_cyc(2);
        periph_rst = 1'b0;
        wait_cyc(8);
        periph_rst = 1'b1;
        wait_cyc(1);
        periph_rst = 1'b0;
        wait_cyc(20);
        chk("R7", "final value", 32'(val), 32'h5A);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule